// File: doc/BRIEF.md
# High-Speed Mode Two-Byte Read Controller

This block is a two-wire bus master that switches the bus into its high-speed mode and then fetches a 16-bit conversion result from one addressed target. Every transaction starts at the slower fast-mode rate. The master sends a special code byte that no target may acknowledge, and then a repeated START. From that point the address byte and both data bytes run at the faster rate, and the transaction ends with a STOP, which returns the bus to fast mode.

The bus lines are open-drain. The block drives each line through an output that, when high, pulls the line low, and it reads the resolved line level back on a separate input. The bit rate of each mode is set by a period input counted in system clock cycles. Some targets need time to start a conversion after they acknowledge their address. For these, an optional stretch keeps SCL high after the ninth rising edge of the address frame for a programmed number of cycles. Software pulses `start` with a 7-bit address, waits for `done`, and then reads `rdata` and `err`.

Top module: `hs_read_master`

## Requirements
- R1: After `start`, the bus shows a START (SDA falls while SCL is high), then the byte {5'b00001, MASTER_ID} sent MSB first at fast-mode timing. MASTER_ID defaults to 3'b011, which gives 8'h0B.
- R2: The ninth bit after the code byte must read high. If SDA reads low there, `err` is set and the transaction ends with a STOP and no repeated START.
- R3: After the ninth bit of the code byte, a repeated START follows, then the byte {tgt_addr, 1'b1} sent MSB first at high-speed timing.
- R4: If the target leaves the address acknowledge bit high, the block sets `err`, issues a STOP, and clocks no data bits.
- R5: With `hold_en` set, SCL stays high for hs_period/2 + hold_cycles clock cycles from the ninth rising edge of the address frame. With `hold_en` clear, it stays high for hs_period/2.
- R6: Two bytes are read MSB first. The master drives the acknowledge bit low after the first byte and leaves it high (not acknowledged) after the second byte.
- R7: Every transaction ends with a STOP (SDA rises while SCL is high). The next transaction again begins with the code byte at fast-mode timing.
- R8: `rdata` = {first byte, second byte}. `done` pulses for exactly one cycle when the STOP sequence completes, and `busy` falls in the same cycle.
- R9: SDA changes only while SCL is low, except for START, repeated START and STOP. Each SCL high phase and low phase lasts period/2 clock cycles of the selected mode (periods even, at least 4).
- R10: A `start` pulse while `busy` is high is ignored. The running transaction keeps its address, and no extra transaction follows.
- R11: After reset and while idle, both line drives are released, and `busy`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request to begin a transaction |
| tgt_addr | input | 7 | Target address, captured on start |
| fs_period | input | CW | Fast-mode SCL period in clock cycles |
| hs_period | input | CW | High-speed SCL period in clock cycles |
| hold_en | input | 1 | Enable the post-address SCL high stretch |
| hold_cycles | input | CW | Length of the stretch in clock cycles |
| scl_oe | output | 1 | Pull SCL low when high |
| scl_in | input | 1 | Resolved SCL level |
| sda_oe | output | 1 | Pull SDA low when high |
| sda_in | input | 1 | Resolved SDA level |
| rdata | output | 16 | Result word, valid with done |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Address or code-byte acknowledge fault |

## Verification
The hardest case to reach from the ports is a target that wrongly acknowledges the high-speed code byte. A compliant target never does this. The bench therefore gives its behavioural target a switch that makes it pull SDA low on that ninth bit, and it then checks that no repeated START appears and that a STOP follows. The stretch after the address acknowledge is measured in the same way. The bench time-stamps the bus edges of the ninth clock of the address frame and compares the high time against the programmed count, both with the stretch enabled and with it disabled.

// File: rtl/hs_read_master.sv
`timescale 1ns/1ps
module hs_read_master #(
  parameter int unsigned CW = 16,
  parameter logic [2:0]  MASTER_ID = 3'b011
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [6:0]    tgt_addr,
  input  logic [CW-1:0] fs_period,
  input  logic [CW-1:0] hs_period,
  input  logic          hold_en,
  input  logic [CW-1:0] hold_cycles,
  output logic          scl_oe,
  input  logic          scl_in,
  output logic          sda_oe,
  input  logic          sda_in,
  output logic [15:0]   rdata,
  output logic          busy,
  output logic          done,
  output logic          err
);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [7:0]    CODE = {5'b00001, MASTER_ID};

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_LO, S_HI, S_HOLD, S_RS_LO, S_RS_HI, S_RS_SDA,
    S_SP_LO, S_SP_HI, S_SP_END
  } st_t;

  st_t          st;
  logic [CW-1:0] cnt, hold_n;
  logic [1:0]   frm;
  logic [3:0]   bitn;
  logic [7:0]   sh;
  logic [15:0]  rx;
  logic [6:0]   addr_q;
  logic         hs, ent, hold_q, scl_q, sda_q;

  wire [CW-1:0] fs_h = fs_period >> 1;
  wire [CW-1:0] hs_h = hs_period >> 1;
  wire [CW-1:0] half = hs ? hs_h : fs_h;
  wire          last = (cnt == '0);
  wire          ack_bit = (bitn == 4'd8);

  assign scl_oe = scl_q;
  assign sda_oe = sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; hold_n <= '0; frm <= '0; bitn <= '0;
      sh <= '0; rx <= '0; addr_q <= '0; hs <= 1'b0; ent <= 1'b0;
      hold_q <= 1'b0; scl_q <= 1'b0; sda_q <= 1'b0;
      rdata <= '0; busy <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          addr_q <= tgt_addr; hold_q <= hold_en; hold_n <= hold_cycles;
          err <= 1'b0; hs <= 1'b0; busy <= 1'b1; rx <= '0;
          sda_q <= 1'b1; cnt <= fs_h - ONE; st <= S_START;
        end
        S_START: if (last) begin
          st <= S_LO; scl_q <= 1'b1; ent <= 1'b1; cnt <= half - ONE;
          frm <= 2'd0; bitn <= 4'd0; sh <= CODE;
        end else cnt <= cnt - ONE;
        S_LO: begin
          if (ent) begin
            ent <= 1'b0;
            if (ack_bit) sda_q <= (frm == 2'd2);
            else         sda_q <= frm[1] ? 1'b0 : ~sh[7];
          end
          if (last) begin st <= S_HI; scl_q <= 1'b0; cnt <= half - ONE; end
          else cnt <= cnt - ONE;
        end
        S_HI: if (scl_in) begin
          if (!last) cnt <= cnt - ONE;
          else if (!ack_bit) begin
            sh <= sh << 1;
            if (frm[1]) rx <= {rx[14:0], sda_in};
            bitn <= bitn + 4'd1;
            st <= S_LO; scl_q <= 1'b1; ent <= 1'b1; cnt <= half - ONE;
          end else begin
            bitn <= 4'd0; frm <= frm + 2'd1;
            case (frm)
              2'd0: if (!sda_in) begin
                err <= 1'b1; st <= S_SP_LO; scl_q <= 1'b1; ent <= 1'b1; cnt <= half - ONE;
              end else begin
                hs <= 1'b1; st <= S_RS_LO; scl_q <= 1'b1; cnt <= hs_h - ONE;
              end
              2'd1: if (sda_in) begin
                err <= 1'b1; st <= S_SP_LO; scl_q <= 1'b1; ent <= 1'b1; cnt <= half - ONE;
              end else if (hold_q && hold_n != '0) begin
                st <= S_HOLD; cnt <= hold_n - ONE;
              end else begin
                st <= S_LO; scl_q <= 1'b1; ent <= 1'b1; cnt <= half - ONE;
              end
              2'd2: begin
                st <= S_LO; scl_q <= 1'b1; ent <= 1'b1; cnt <= half - ONE;
              end
              default: begin
                rdata <= rx; st <= S_SP_LO; scl_q <= 1'b1; ent <= 1'b1; cnt <= half - ONE;
              end
            endcase
          end
        end
        S_HOLD: if (last) begin
          st <= S_LO; scl_q <= 1'b1; ent <= 1'b1; cnt <= half - ONE;
        end else cnt <= cnt - ONE;
        S_RS_LO: if (last) begin st <= S_RS_HI; scl_q <= 1'b0; cnt <= half - ONE; end
                 else cnt <= cnt - ONE;
        S_RS_HI: if (scl_in) begin
          if (last) begin sda_q <= 1'b1; st <= S_RS_SDA; cnt <= half - ONE; end
          else cnt <= cnt - ONE;
        end
        S_RS_SDA: if (last) begin
          st <= S_LO; scl_q <= 1'b1; ent <= 1'b1; cnt <= half - ONE;
          frm <= 2'd1; bitn <= 4'd0; sh <= {addr_q, 1'b1};
        end else cnt <= cnt - ONE;
        S_SP_LO: begin
          if (ent) begin ent <= 1'b0; sda_q <= 1'b1; end
          if (last) begin st <= S_SP_HI; scl_q <= 1'b0; cnt <= half - ONE; end
          else cnt <= cnt - ONE;
        end
        S_SP_HI: if (scl_in) begin
          if (last) begin sda_q <= 1'b0; st <= S_SP_END; cnt <= half - ONE; end
          else cnt <= cnt - ONE;
        end
        S_SP_END: if (last) begin
          st <= S_IDLE; busy <= 1'b0; done <= 1'b1; hs <= 1'b0;
        end else cnt <= cnt - ONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_q && !$past(scl_q) && (sda_q != $past(sda_q))) |->
    ($past(st) inside {S_IDLE, S_RS_HI, S_SP_HI})); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !scl_q && !sda_q)); // R8
  AST_ERR_ENDS_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (st == S_SP_LO && scl_q)); // R4
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(addr_q)); // R10
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> (!scl_q && !sda_q)); // R11
endmodule

// File: tb/hs_read_master_tb.sv
`timescale 1ns/1ps
module hs_read_master_tb;
  localparam int CW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic start = 1'b0, hold_en = 1'b0;
  logic [6:0] tgt_addr = '0;
  logic [CW-1:0] fs_period = 16'd40, hs_period = 16'd8, hold_cycles = '0;
  logic scl_oe, sda_oe, busy, done, err;
  logic [15:0] rdata;
  logic slv_drv = 1'b0;
  wire scl_b = !scl_oe;
  wire sda_b = !(sda_oe || slv_drv);

  hs_read_master #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_addr(tgt_addr),
    .fs_period(fs_period), .hs_period(hs_period), .hold_en(hold_en),
    .hold_cycles(hold_cycles), .scl_oe(scl_oe), .scl_in(scl_b),
    .sda_oe(sda_oe), .sda_in(sda_b), .rdata(rdata), .busy(busy),
    .done(done), .err(err));

  int n_chk = 0, n_bad = 0;
  logic [6:0] s_addr = 7'h48;
  logic s_ack = 1'b1, s_mc_ack = 1'b0;
  logic [7:0] d_hi = 8'h00, d_lo = 8'h00;

  int n_start = 0, n_stop = 0, st_base = 0, k_st = 0, n_dbits = 0, n_done = 0;
  int sc = 0, sf = 0, hi = 0, mc_hi = 0, ad_hi = 0, hold_hi = 0, dat_hi = 0;
  logic rd = 1'b0, pscl = 1'b1, psda = 1'b1, ack1 = 1'b1, ack2 = 1'b0;
  logic [7:0] shv = '0, txb = '0, mc_byte = '0, ad_byte = '0;
  time t_rise = 0;

  always @(negedge clk) if (done) n_done++;

  always @(scl_b, sda_b) begin
    if (scl_b === 1'b1 && pscl === 1'b1 && sda_b !== psda) begin
      if (sda_b === 1'b0) begin
        n_start++; k_st = n_start - st_base; sc = 0; sf = 0; rd = 1'b0;
      end else if (sda_b === 1'b1) begin
        n_stop++; st_base = n_start;
      end
    end else if (scl_b === 1'b1 && pscl === 1'b0) begin
      t_rise = $time;
      if (sc < 8) shv = {shv[6:0], sda_b};
      else if (rd && sf == 1) ack1 = sda_b;
      else if (rd && sf == 2) ack2 = sda_b;
      if (rd && sf != 0 && sc < 8) n_dbits++;
      sc++;
    end else if (scl_b === 1'b0 && pscl === 1'b1) begin
      hi = int'(($time - t_rise) / 20);
      if (sf == 0 && sc == 1 && k_st == 1) mc_hi = hi;
      if (sf == 0 && sc == 1 && k_st == 2) ad_hi = hi;
      if (sf == 0 && sc == 9 && rd) hold_hi = hi;
      if (sf == 1 && sc == 1 && rd) dat_hi = hi;
      if (sc == 8) begin
        if (sf == 0 && shv[7:3] == 5'b00001) begin mc_byte = shv; slv_drv = s_mc_ack; end
        else if (sf == 0) begin
          ad_byte = shv;
          if (shv == {s_addr, 1'b1} && s_ack) begin slv_drv = 1'b1; rd = 1'b1; end
        end else slv_drv = 1'b0;
      end else if (sc == 9) begin
        sc = 0; sf++;
        txb = (sf == 1) ? d_hi : d_lo;
        slv_drv = rd && sf <= 2 && !txb[7];
      end else if (rd && sf >= 1 && sf <= 2) begin
        txb = (sf == 1) ? d_hi : d_lo;
        slv_drv = !txb[3'(7 - sc)];
      end else slv_drv = 1'b0;
    end
    pscl = scl_b; psda = sda_b;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic kick(input logic [6:0] a, input logic he, input logic [CW-1:0] hc);
    @(negedge clk);
    tgt_addr = a; hold_en = he; hold_cycles = hc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    chk("R8 done seen", {31'd0, done}, 32'd1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R11 reset scl_oe", {31'd0, scl_oe}, 32'd0);
    chk("R11 reset sda_oe", {31'd0, sda_oe}, 32'd0);
    chk("R11 reset busy/done/err", {29'd0, busy, done, err}, 32'd0);
  endtask

  task automatic t_read_hold();
    int s0 = n_start, p0 = n_stop, d0 = n_done;
    s_addr = 7'h48; s_ack = 1'b1; s_mc_ack = 1'b0; d_hi = 8'hA5; d_lo = 8'h3C;
    kick(7'h48, 1'b1, 16'd100);
    chk("R11 busy after start", {31'd0, busy}, 32'd1);
    wait_done();
    chk("R8 rdata", {16'd0, rdata}, 32'hA53C);
    chk("R2 no err", {31'd0, err}, 32'd0);
    chk("R8 busy low with done", {31'd0, busy}, 32'd0);
    chk("R1 code byte", {24'd0, mc_byte}, 32'h0B);
    chk("R3 address byte", {24'd0, ad_byte}, {24'd0, 8'h91});
    chk("R3 start plus repeated start", n_start - s0, 2);
    chk("R7 stop count", n_stop - p0, 1);
    chk("R6 master ack first byte", {31'd0, ack1}, 32'd0);
    chk("R6 master nack second byte", {31'd0, ack2}, 32'd1);
    chk("R5 stretched high", hold_hi, 104);
    chk("R9 fast-mode high phase", mc_hi, 20);
    chk("R9 high-speed address high", ad_hi, 4);
    chk("R9 high-speed data high", dat_hi, 4);
    repeat (5) @(negedge clk);
    chk("R8 single done pulse", n_done - d0, 1);
    chk("R11 lines released idle", {30'd0, scl_oe, sda_oe}, 32'd0);
  endtask

  task automatic t_addr_nack();
    int p0 = n_stop, b0 = n_dbits;
    s_ack = 1'b0; s_mc_ack = 1'b0;
    kick(7'h48, 1'b0, 16'd0);
    wait_done();
    chk("R4 err on address nack", {31'd0, err}, 32'd1);
    chk("R4 stop after nack", n_stop - p0, 1);
    chk("R4 no data clocks", n_dbits - b0, 0);
    s_ack = 1'b1;
  endtask

  task automatic t_read_nohold();
    int s0 = n_start;
    mc_byte = 8'h00;
    s_addr = 7'h2C; d_hi = 8'h01; d_lo = 8'hFE;
    kick(7'h2C, 1'b0, 16'd100);
    wait_done();
    chk("R7 code byte resent", {24'd0, mc_byte}, 32'h0B);
    chk("R7 two starts again", n_start - s0, 2);
    chk("R5 no stretch", hold_hi, 4);
    chk("R6 data bytes", {16'd0, rdata}, 32'h01FE);
    chk("R2 err cleared", {31'd0, err}, 32'd0);
  endtask

  task automatic t_code_acked();
    int s0 = n_start, p0 = n_stop;
    s_mc_ack = 1'b1;
    kick(7'h2C, 1'b0, 16'd0);
    wait_done();
    chk("R2 err on code ack", {31'd0, err}, 32'd1);
    chk("R2 no repeated start", n_start - s0, 1);
    chk("R2 stop issued", n_stop - p0, 1);
    s_mc_ack = 1'b0;
  endtask

  task automatic t_busy_start();
    int s0 = n_start;
    s_addr = 7'h48; d_hi = 8'h77; d_lo = 8'h10;
    kick(7'h48, 1'b0, 16'd0);
    repeat (300) @(negedge clk);
    kick(7'h2C, 1'b0, 16'd0);
    wait_done();
    chk("R10 address kept", {24'd0, ad_byte}, 32'h91);
    chk("R10 data", {16'd0, rdata}, 32'h7710);
    repeat (200) @(negedge clk);
    chk("R10 no extra transaction", n_start - s0, 2);
    chk("R10 idle after", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL R8 watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read_hold();
    t_addr_nack();
    t_read_nohold();
    t_code_acked();
    t_busy_start();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule